// File: doc/BRIEF.md
# Coherency Port Enable Controller

This block owns the snoop-request and DVM-message enables for the slave interfaces of a coherent interconnect. By default there are five interfaces: two full-coherency processor cluster ports followed by three I/O-coherent ports. Software writes a two-bit enable value into a per-port control register. The new value does not take effect immediately. The controller first raises a request towards the port, carrying the requested enables, and the value only becomes effective when the port returns an acknowledge. That acknowledge arrives once the port has drained its outstanding snoop traffic.

One shared status register carries a single change-pending flag. The flag is set whenever any port has a requested value that differs from its effective value, or has a handshake in flight. Software polls the flag until it reads zero before it treats an enable change as complete. The address space is split into windows of 2^WIN_SHIFT bytes. Window 0 holds the status register at offset 0xC. Window p+1 holds the control register of port p at offset 0x0.

Top module: `coh_port_enable_ctrl`

## Requirements
- R1: After reset, every port has snoop and DVM disabled, no request is raised, every control register reads 0, and the status register reads 0.
- R2: The control register of port p sits at offset 0x0 of address window p+1. Bit 0 is the snoop enable and bit 1 is the DVM enable. A read returns the effective (acknowledged) enables.
- R3: Writing 0x3 to a full-coherency port eventually turns on both snoop and DVM. Writing 0x0 turns both off.
- R4: The I/O-coherent ports (indices NUM_FULL and above) have no DVM. Bit 1 of their control register reads as zero and their dvm_en output stays 0.
- R5: A write that changes a port's requested enables makes the pending flag read 1 in the cycle after the write. The port's request is raised one cycle after the write.
- R6: A port's effective enables, and its snoop_en/dvm_en outputs, change only on a cycle in which its request and acknowledge are both high. They take the requested value.
- R7: Pending clears in the cycle after the last outstanding acknowledge is received. For an acknowledge delay of d cycles after the request is seen, pending reads 1 for exactly d+2 cycles. With several ports busy, it stays set until the slowest one finishes.
- R8: A write whose masked value equals the current effective value, with nothing in flight, leaves pending at 0 and raises no request.
- R9: The status register sits at offset 0xC of window 0. Bit 0 is the pending flag and all other bits read 0.
- R10: While a request is raised and not yet acknowledged, the request stays high and its value stays stable. A write during a handshake is served by a second handshake to the last written value once the first completes. Pending stays set throughout.
- R11: Writes to unmapped offsets, to windows above the last port, or to the status register change no enable and do not set pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read byte address (combinational read) |
| rd_data | output | DATA_W | Read data |
| port_req | output | NUM_FULL+NUM_IO | Per-port enable-change request (level) |
| port_req_val | output | 2*(NUM_FULL+NUM_IO) | Requested enables, two bits per port |
| port_ack | input | NUM_FULL+NUM_IO | Per-port acknowledge pulse |
| snoop_en | output | NUM_FULL+NUM_IO | Effective snoop enable per port |
| dvm_en | output | NUM_FULL+NUM_IO | Effective DVM enable per port |

## Verification
On every cycle, the assertions check four things. A request holds high with a stable value until it is acknowledged. Effective enables move only on a request-acknowledge pair. An idle port with a mismatch raises its request in the next cycle. Pending rises only after a write and falls only after an acknowledge. The exact pending duration for each acknowledge delay can only be shown by the bench's scenarios. So can the masking of the DVM bit on I/O ports, the overlap of a slow and a fast port, a rewrite during a handshake producing a second request, and ignored writes to unmapped addresses. The bench measures each of these against expected values computed from the delays it programs.

// File: rtl/cpe_pkg.sv
package cpe_pkg;
   localparam int unsigned EN_W      = 2;
   localparam int unsigned SNOOP_BIT = 0;
   localparam int unsigned DVM_BIT   = 1;

   typedef enum logic {
      HS_IDLE = 1'b0,
      HS_WAIT = 1'b1
   } hs_state_t;
endpackage

// File: rtl/cpe_addr_decode.sv
module cpe_addr_decode #(
   parameter int NUM_PORTS = 5,
   parameter int ADDR_W    = 16,
   parameter int WIN_SHIFT = 12,
   parameter int CTRL_OFS  = 0,
   parameter int STAT_OFS  = 12
) (
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [NUM_PORTS-1:0] wr_hit,
   output logic [NUM_PORTS-1:0] rd_port_hit,
   output logic                 rd_stat_hit
);
   localparam int WIN_W = ADDR_W - WIN_SHIFT;

   if (WIN_W < 1) begin : g_bad_win
      $error("address has no room for a window index");
   end
   if ((NUM_PORTS + 1) > (1 << WIN_W)) begin : g_bad_ports
      $error("too many ports for the window index width");
   end
   if (CTRL_OFS >= (1 << WIN_SHIFT) || STAT_OFS >= (1 << WIN_SHIFT)) begin : g_bad_ofs
      $error("register offset outside its window");
   end

   logic [WIN_W-1:0]     wr_win;
   logic [WIN_W-1:0]     rd_win;
   logic [WIN_SHIFT-1:0] wr_ofs;
   logic [WIN_SHIFT-1:0] rd_ofs;

   assign wr_win = wr_addr[ADDR_W-1:WIN_SHIFT];
   assign rd_win = rd_addr[ADDR_W-1:WIN_SHIFT];
   assign wr_ofs = wr_addr[WIN_SHIFT-1:0];
   assign rd_ofs = rd_addr[WIN_SHIFT-1:0];

   assign rd_stat_hit = (rd_win == '0) && (rd_ofs == WIN_SHIFT'(STAT_OFS));

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
      assign wr_hit[p]      = wr_en && (wr_win == WIN_W'(p + 1))
                              && (wr_ofs == WIN_SHIFT'(CTRL_OFS));
      assign rd_port_hit[p] = (rd_win == WIN_W'(p + 1))
                              && (rd_ofs == WIN_SHIFT'(CTRL_OFS));
   end
endmodule

// File: rtl/cpe_port_ctrl.sv
module cpe_port_ctrl
   import cpe_pkg::*;
#(
   parameter bit HAS_DVM = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_hit,
   input  logic [EN_W-1:0] wr_bits,
   input  logic            ack,
   output logic            req,
   output logic [EN_W-1:0] req_val,
   output logic [EN_W-1:0] eff,
   output logic            busy
);
   localparam logic [EN_W-1:0] EN_MASK = HAS_DVM ? 2'b11 : 2'b01;

   hs_state_t       state_q;
   logic [EN_W-1:0] target_q;
   logic [EN_W-1:0] eff_q;
   logic [EN_W-1:0] req_val_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= HS_IDLE;
         target_q  <= '0;
         eff_q     <= '0;
         req_val_q <= '0;
      end else begin
         if (wr_hit) begin
            target_q <= wr_bits & EN_MASK;
         end
         case (state_q)
            HS_IDLE: begin
               if (target_q != eff_q) begin
                  state_q   <= HS_WAIT;
                  req_val_q <= target_q;
               end
            end
            HS_WAIT: begin
               if (ack) begin
                  eff_q   <= req_val_q;
                  state_q <= HS_IDLE;
               end
            end
            default: state_q <= HS_IDLE;
         endcase
      end
   end

   assign req     = (state_q == HS_WAIT);
   assign req_val = req_val_q;
   assign eff     = eff_q;
   assign busy    = (state_q == HS_WAIT) || (target_q != eff_q);

   // R10: request held with stable value until acknowledged
   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !ack) |=> (req && $stable(req_val)));

   // R6: effective enables move only on a request/acknowledge pair
   p_eff_only_on_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(req && ack) |=> $stable(eff));

   // R5: an idle port with a mismatch raises its request next cycle
   p_req_follows_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!req && (target_q != eff_q)) |=> req);

   if (!HAS_DVM) begin : g_io_variant
      // R4: I/O-coherent port never carries a DVM request
      p_io_no_dvm_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
         req |-> (req_val[DVM_BIT] == 1'b0));
   end
endmodule

// File: rtl/cpe_readback.sv
module cpe_readback
   import cpe_pkg::*;
#(
   parameter int NUM_PORTS = 5,
   parameter int DATA_W    = 32
) (
   input  logic [NUM_PORTS-1:0]      busy,
   input  logic [EN_W*NUM_PORTS-1:0] eff_flat,
   input  logic [NUM_PORTS-1:0]      rd_port_hit,
   input  logic                      rd_stat_hit,
   output logic                      pending,
   output logic [DATA_W-1:0]         rd_data
);
   if (DATA_W < EN_W) begin : g_bad_data
      $error("data width narrower than an enable field");
   end

   assign pending = |busy;

   always_comb begin
      rd_data = '0;
      if (rd_stat_hit) begin
         rd_data[0] = pending;
      end
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (rd_port_hit[p]) begin
            rd_data[EN_W-1:0] = eff_flat[EN_W*p +: EN_W];
         end
      end
   end
endmodule

// File: rtl/coh_port_enable_ctrl.sv
module coh_port_enable_ctrl
   import cpe_pkg::*;
#(
   parameter int NUM_FULL  = 2,
   parameter int NUM_IO    = 3,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter int WIN_SHIFT = 12
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [ADDR_W-1:0]              wr_addr,
   input  logic [DATA_W-1:0]              wr_data,
   input  logic [ADDR_W-1:0]              rd_addr,
   output logic [DATA_W-1:0]              rd_data,
   output logic [NUM_FULL+NUM_IO-1:0]     port_req,
   output logic [2*(NUM_FULL+NUM_IO)-1:0] port_req_val,
   input  logic [NUM_FULL+NUM_IO-1:0]     port_ack,
   output logic [NUM_FULL+NUM_IO-1:0]     snoop_en,
   output logic [NUM_FULL+NUM_IO-1:0]     dvm_en
);
   localparam int NUM_PORTS = NUM_FULL + NUM_IO;
   localparam int CTRL_OFS  = 'h0;
   localparam int STAT_OFS  = 'hC;

   if (NUM_PORTS < 1) begin : g_bad_count
      $error("at least one port is required");
   end
   if (NUM_FULL < 0 || NUM_IO < 0) begin : g_bad_mix
      $error("port counts must not be negative");
   end

   logic [NUM_PORTS-1:0]      wr_hit;
   logic [NUM_PORTS-1:0]      rd_port_hit;
   logic                      rd_stat_hit;
   logic [NUM_PORTS-1:0]      busy;
   logic [EN_W*NUM_PORTS-1:0] eff_flat;
   logic                      pending;
   logic                      unused_wdata;

   assign unused_wdata = ^wr_data[DATA_W-1:EN_W];

   cpe_addr_decode #(
      .NUM_PORTS (NUM_PORTS),
      .ADDR_W    (ADDR_W),
      .WIN_SHIFT (WIN_SHIFT),
      .CTRL_OFS  (CTRL_OFS),
      .STAT_OFS  (STAT_OFS)
   ) u_dec (
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .rd_addr     (rd_addr),
      .wr_hit      (wr_hit),
      .rd_port_hit (rd_port_hit),
      .rd_stat_hit (rd_stat_hit)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam bit IS_FULL = (p < NUM_FULL);
      logic [EN_W-1:0] eff_p;
      logic [EN_W-1:0] rv_p;

      cpe_port_ctrl #(
         .HAS_DVM (IS_FULL)
      ) u_port (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_hit  (wr_hit[p]),
         .wr_bits (wr_data[EN_W-1:0]),
         .ack     (port_ack[p]),
         .req     (port_req[p]),
         .req_val (rv_p),
         .eff     (eff_p),
         .busy    (busy[p])
      );

      assign port_req_val[EN_W*p +: EN_W] = rv_p;
      assign eff_flat[EN_W*p +: EN_W]     = eff_p;
      assign snoop_en[p]                  = eff_p[SNOOP_BIT];

      if (IS_FULL) begin : g_full
         assign dvm_en[p] = eff_p[DVM_BIT];
      end else begin : g_io
         assign dvm_en[p] = 1'b0;
      end
   end

   cpe_readback #(
      .NUM_PORTS (NUM_PORTS),
      .DATA_W    (DATA_W)
   ) u_rb (
      .busy        (busy),
      .eff_flat    (eff_flat),
      .rd_port_hit (rd_port_hit),
      .rd_stat_hit (rd_stat_hit),
      .pending     (pending),
      .rd_data     (rd_data)
   );

   // R7: pending falls only after some port's acknowledge was taken
   p_pending_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pending) |-> $past(|(port_req & port_ack)));

   // R5: pending rises only as a result of a register write
   p_pending_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending) |-> $past(wr_en));

   // R1: requests stay low while in reset
   p_reset_quiet_r1: assert property (@(posedge clk)
      $past(!rst_n) |-> (port_req == '0 && snoop_en == '0 && dvm_en == '0));
endmodule

// File: tb/tb_coh_port_enable_ctrl.sv
`timescale 1ns/1ps
module tb_coh_port_enable_ctrl;
   localparam int NP = 5;
   localparam int NF = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [15:0]   wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic [15:0]   rd_addr = '0;
   logic [31:0]   rd_data;
   logic [NP-1:0] port_req;
   logic [2*NP-1:0] port_req_val;
   logic [NP-1:0] port_ack = '0;
   logic [NP-1:0] snoop_en;
   logic [NP-1:0] dvm_en;

   int checks = 0;
   int failures = 0;
   int dly [NP];
   int cnt [NP];
   int rises [NP];
   logic [NP-1:0] req_prev = '0;
   int exp_eff [NP];

   always #4 clk = ~clk;

   coh_port_enable_ctrl dut (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
      .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
      .port_req (port_req), .port_req_val (port_req_val), .port_ack (port_ack),
      .snoop_en (snoop_en), .dvm_en (dvm_en)
   );

   // acknowledge responder: ack sampled d+1 edges after the request is seen
   always @(negedge clk) begin
      for (int p = 0; p < NP; p++) begin
         if (port_req[p] && !req_prev[p]) rises[p] = rises[p] + 1;
         req_prev[p] <= port_req[p];
         if (!rst_n) begin
            port_ack[p] <= 1'b0;
            cnt[p]      <= 0;
         end else if (port_ack[p]) begin
            port_ack[p] <= 1'b0;
            cnt[p]      <= 0;
         end else if (port_req[p]) begin
            if (cnt[p] >= dly[p]) begin
               port_ack[p] <= 1'b1;
               cnt[p]      <= 0;
            end else begin
               cnt[p] <= cnt[p] + 1;
            end
         end else begin
            cnt[p] <= 0;
         end
      end
   end

   function automatic logic [15:0] mk(input int win, input int ofs);
      return 16'((win << 12) | ofs);
   endfunction

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic do_wr(input int win, input int ofs, input int data);
      wr_addr = mk(win, ofs);
      wr_data = 32'(data);
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic rd(input int win, input int ofs, output int val);
      rd_addr = mk(win, ofs);
      #1;
      val = int'(rd_data);
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      rd_addr = mk(0, 'hC);
      #1;
      while (rd_data[0] && n < 300) begin
         n++;
         @(negedge clk);
         #1;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int p = 0; p < NP; p++) exp_eff[p] = 0;
   endtask

   task automatic check_port_state(input int p, input string rq);
      int v;
      rd(p + 1, 0, v);
      chk(v == exp_eff[p], rq, v, exp_eff[p]);
      chk(snoop_en[p] == exp_eff[p][0], rq, int'(snoop_en[p]), exp_eff[p] & 1);
      chk(dvm_en[p] == exp_eff[p][1], rq, int'(dvm_en[p]), (exp_eff[p] >> 1) & 1);
   endtask

   initial begin
      #(8 * 200000);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int v, n, base;
      for (int p = 0; p < NP; p++) begin
         dly[p] = 0;
         rises[p] = 0;
      end
      do_reset();

      // R1: reset state
      for (int p = 0; p < NP; p++) check_port_state(p, "R1 reset port");
      rd(0, 'hC, v);
      chk(v == 0, "R1 R9 status after reset", v, 0);
      chk(port_req == '0, "R1 no request after reset", int'(port_req), 0);

      // R2 R3 R4 R5 R6 R7 R8: sweep every port over every value
      for (int p = 0; p < NP; p++) begin
         for (int val = 0; val < 4; val++) begin
            int old_v, new_v, d;
            bit changed;
            d = (p * 3 + val) % 5;
            dly[p] = d;
            old_v = exp_eff[p];
            new_v = (p < NF) ? val : (val & 1);
            changed = (new_v != old_v);
            do_wr(p + 1, 0, val);
            #1;
            chk(snoop_en[p] == old_v[0], "R6 snoop unchanged before ack",
                int'(snoop_en[p]), old_v & 1);
            chk(dvm_en[p] == old_v[1], "R6 dvm unchanged before ack",
                int'(dvm_en[p]), (old_v >> 1) & 1);
            rd(0, 'hC, v);
            chk(v == int'(changed), changed ? "R5 pending set by change" : "R8 pending after same value",
                v, int'(changed));
            if (changed) begin
               wait_idle(n);
               chk(n == d + 2, "R7 pending duration", n, d + 2);
            end else begin
               for (int k = 0; k < 3; k++) begin
                  @(negedge clk);
                  rd(0, 'hC, v);
                  chk(v == 0, "R8 no pending for unchanged write", v, 0);
               end
            end
            exp_eff[p] = new_v;
            check_port_state(p, (p < NF) ? "R2 R3 readback full port" : "R2 R4 readback io port");
         end
         // rewrite the same value: R8
         base = rises[p];
         do_wr(p + 1, 0, 3);
         repeat (3) @(negedge clk);
         rd(0, 'hC, v);
         chk(v == 0, "R8 rewrite same value keeps pending low", v, 0);
         chk(rises[p] == base, "R8 no request on same value", rises[p] - base, 0);
      end

      // R4: io port DVM bit stays zero after writing 2
      do_reset();
      dly[3] = 1;
      do_wr(4, 0, 2);
      repeat (4) @(negedge clk);
      rd(4, 0, v);
      chk(v == 0, "R4 io dvm bit read as zero", v, 0);
      chk(dvm_en[3] == 1'b0, "R4 io dvm output low", int'(dvm_en[3]), 0);

      // R7: slow full port and fast io port overlapping
      do_reset();
      dly[0] = 5;
      dly[3] = 1;
      do_wr(1, 0, 3);
      #1;
      rd(0, 'hC, v);
      chk(v == 1, "R5 pending after first write", v, 1);
      do_wr(4, 0, 1);
      wait_idle(n);
      chk(n == 6, "R7 pending held until slowest port", n, 6);
      exp_eff[0] = 3;
      exp_eff[3] = 1;
      check_port_state(0, "R7 slow port final");
      check_port_state(3, "R7 fast port final");

      // R10: rewrite during a handshake triggers a second handshake
      do_reset();
      dly[1] = 4;
      base = rises[1];
      do_wr(2, 0, 3);
      do_wr(2, 0, 0);
      wait_idle(n);
      chk(n == 11, "R10 pending continuous across two handshakes", n, 11);
      chk(rises[1] - base == 2, "R10 two requests issued", rises[1] - base, 2);
      check_port_state(1, "R10 last written value wins");

      // R11: ignored writes
      do_reset();
      base = rises[0] + rises[4];
      do_wr(1, 4, 3);
      do_wr(6, 0, 3);
      do_wr(0, 'hC, 3);
      do_wr(0, 0, 3);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         rd(0, 'hC, v);
         chk(v == 0, "R11 R9 no pending from unmapped write", v, 0);
      end
      chk(rises[0] + rises[4] == base, "R11 no request from unmapped write",
          rises[0] + rises[4] - base, 0);
      for (int p = 0; p < NP; p++) check_port_state(p, "R11 enables untouched");

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule